// File: doc/BRIEF.md
# Fixed-Point Status Flag and Condition Updater

This block holds the status bits that an integer pipeline produces alongside each ALU result. These are unsigned carry, a carry taken at the 32-bit boundary, signed overflow, signed overflow of the low word, and a sticky summary overflow. It also holds a small bank of 4-bit condition fields. The ALU result itself is computed elsewhere. This block sees the operands and the finished result, and derives the flags from those values alone.

On each cycle that carries an update strobe, the block does the following:

- It optionally inverts the first operand.
- It replaces the second operand with an immediate when one is valid.
- It evaluates carry and overflow at both widths.
- It merges the results into its registers under per-flag enables.

A divide unit can supply an overflow verdict of its own, which then overrides the arithmetic rule. When recording is enabled, a sign/zero summary of the result is written into the selected condition field.

Top module: `fxu_flag_unit`

## Requirements
- R1: After synchronous reset, every flag output and every condition bit is 0.
- R2: With `upd_valid` low, no flag and no condition bit changes, whatever the other inputs are.
- R3: With `inv_a` high, the bitwise complement of `op_a` is used as the first operand. With `imm_valid` high, `imm_data` is used as the second operand and `op_b` is ignored.
- R4: With `carry_en` high, `ca` becomes 1 exactly when some operand is unsigned-greater than the full-width `result`. When neither `b_used` nor `imm_valid` is set, only the first operand takes part.
- R5: With `carry_en` high and `is_add` high, `ca32` becomes `result[32] ^ a[32] ^ b[32]`. With `is_add` low, it uses the unsigned-greater rule of R4 applied to the low 32 bits.
- R6: With `ovf_en` high, two operands present and no divide verdict, `ov` is 1 when both operands share a sign and the result sign differs. `ov32` uses the same rule on bit 31. With a single operand, `ov` and `ov32` keep their values.
- R7: With `ovf_en` and `div_ovf_valid` high, both `ov` and `ov32` take `div_ovf_bit`.
- R8: `so` is ORed with each newly written overflow value and is only cleared by reset.
- R9: With `rec_en` high, condition field k = `cr_sel` occupies `cr_bits[4k+3:4k]`. It receives {negative, positive, zero, so}, where bit 3 is negative, bit 0 is `so`, the sign is the result's top bit, and `so` is its value after this update. The other fields are unchanged.
- R10: `carry_skip[0]` high keeps `ca` unchanged, and `carry_skip[1]` high keeps `ca32` unchanged, because the instruction writes those bits itself.
- R11: With `carry_en` low, `ca` and `ca32` keep their values. With `ovf_en` low, `ov`, `ov32` and `so` keep theirs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update strobe |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| b_used | input | 1 | Second operand present |
| inv_a | input | 1 | Complement first operand |
| imm_valid | input | 1 | Immediate replaces second operand |
| imm_data | input | 64 | Immediate value |
| result | input | 64 | ALU result |
| is_add | input | 1 | Operation is an add |
| carry_en | input | 1 | Update carry bits |
| ovf_en | input | 1 | Update overflow bits |
| rec_en | input | 1 | Write condition field |
| cr_sel | input | 3 | Condition field index |
| div_ovf_valid | input | 1 | Divide overflow verdict present |
| div_ovf_bit | input | 1 | Divide overflow verdict |
| carry_skip | input | 2 | Suppress ca (bit 0) / ca32 (bit 1) |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-word carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Low-word overflow |
| so | output | 1 | Sticky summary overflow |
| cr_bits | output | 32 | All condition fields, field k at [4k+3:4k] |

## Verification
The bench builds the block with its defaults: a 64-bit datapath, the half-word boundary at bit 32, and eight condition fields. These values make operands that straddle bit 32 meaningful, so the add-only XOR carry and the low-word compare can be told apart. They also make the top field index 7 and the sign bits 63 and 31 reachable with directed constants.

// File: rtl/fxu_flag_pkg.sv
package fxu_flag_pkg;
  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
  } fx_flags_t;
endpackage

// File: rtl/fxu_carry_calc.sv
module fxu_carry_calc #(
  parameter int W  = 64,
  parameter int LW = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         b_on,
  input  logic [W-1:0] res,
  input  logic         is_add,
  output logic         ca,
  output logic         ca32
);
  logic a_gt, b_gt, a_gt_lo, b_gt_lo;

  always_comb begin
    a_gt    = a > res;
    b_gt    = b_on && (b > res);
    a_gt_lo = a[LW-1:0] > res[LW-1:0];
    b_gt_lo = b_on && (b[LW-1:0] > res[LW-1:0]);
    ca      = a_gt | b_gt;
    if (is_add) ca32 = res[LW] ^ a[LW] ^ (b_on & b[LW]);
    else        ca32 = a_gt_lo | b_gt_lo;
  end
endmodule

// File: rtl/fxu_ovf_calc.sv
module fxu_ovf_calc #(
  parameter int W  = 64,
  parameter int LW = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  output logic         ov,
  output logic         ov32
);
  always_comb begin
    ov   = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
    ov32 = (a[LW-1] == b[LW-1]) && (res[LW-1] != a[LW-1]);
  end
endmodule

// File: rtl/fxu_cond_calc.sv
module fxu_cond_calc #(
  parameter int W = 64
) (
  input  logic [W-1:0] res,
  input  logic         so_in,
  output logic [3:0]   field
);
  logic neg, zer;

  always_comb begin
    neg   = res[W-1];
    zer   = (res == '0);
    field = {neg, !neg && !zer, zer, so_in};
  end
endmodule

// File: rtl/fxu_flag_unit.sv
module fxu_flag_unit
  import fxu_flag_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int HALF_W  = 32,
  parameter int NUM_FLD = 8,
  localparam int SEL_W  = (NUM_FLD > 1) ? $clog2(NUM_FLD) : 1,
  localparam int CR_W   = 4 * NUM_FLD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic              b_used,
  input  logic              inv_a,
  input  logic              imm_valid,
  input  logic [XLEN-1:0]   imm_data,
  input  logic [XLEN-1:0]   result,
  input  logic              is_add,
  input  logic              carry_en,
  input  logic              ovf_en,
  input  logic              rec_en,
  input  logic [SEL_W-1:0]  cr_sel,
  input  logic              div_ovf_valid,
  input  logic              div_ovf_bit,
  input  logic [1:0]        carry_skip,
  output logic              ca,
  output logic              ca32,
  output logic              ov,
  output logic              ov32,
  output logic              so,
  output logic [CR_W-1:0]   cr_bits
);
  fx_flags_t flg_q, flg_d;
  logic [XLEN-1:0] opa_eff, opb_eff;
  logic            two_ops;
  logic            ca_c, ca32_c, ov_c, ov32_c;
  logic [3:0]      new_fld;
  logic [CR_W-1:0] cr_q;

  always_comb begin
    opa_eff = inv_a ? ~op_a : op_a;
    opb_eff = imm_valid ? imm_data : op_b;
    two_ops = b_used | imm_valid;
  end

  fxu_carry_calc #(.W(XLEN), .LW(HALF_W)) u_carry (
    .a(opa_eff), .b(opb_eff), .b_on(two_ops), .res(result),
    .is_add(is_add), .ca(ca_c), .ca32(ca32_c)
  );

  fxu_ovf_calc #(.W(XLEN), .LW(HALF_W)) u_ovf (
    .a(opa_eff), .b(opb_eff), .res(result), .ov(ov_c), .ov32(ov32_c)
  );

  always_comb begin
    flg_d = flg_q;
    if (carry_en) begin
      if (!carry_skip[0]) flg_d.ca   = ca_c;
      if (!carry_skip[1]) flg_d.ca32 = ca32_c;
    end
    if (ovf_en) begin
      if (div_ovf_valid) begin
        flg_d.ov   = div_ovf_bit;
        flg_d.ov32 = div_ovf_bit;
        flg_d.so   = flg_q.so | div_ovf_bit;
      end else if (two_ops) begin
        flg_d.ov   = ov_c;
        flg_d.ov32 = ov32_c;
        flg_d.so   = flg_q.so | ov_c;
      end
    end
  end

  fxu_cond_calc #(.W(XLEN)) u_cond (
    .res(result), .so_in(flg_d.so), .field(new_fld)
  );

  always_ff @(posedge clk) begin
    if (rst)            flg_q <= '0;
    else if (upd_valid) flg_q <= flg_d;
  end

  for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst)
        cr_q[4*k +: 4] <= 4'h0;
      else if (upd_valid && rec_en && (cr_sel == SEL_W'(k)))
        cr_q[4*k +: 4] <= new_fld;
    end
  end

  assign ca      = flg_q.ca;
  assign ca32    = flg_q.ca32;
  assign ov      = flg_q.ov;
  assign ov32    = flg_q.ov32;
  assign so      = flg_q.so;
  assign cr_bits = cr_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (flg_q == '0 && cr_q == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> ($stable(flg_q) && $stable(cr_q))); // R2
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst) so |=> so); // R8
  AST_DIV_BOTH: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && ovf_en && div_ovf_valid) |=> (ov == ov32)); // R7
  AST_CR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !rec_en) |=> $stable(cr_q)); // R9
  AST_CA_SKIP: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && carry_skip[0]) |=> $stable(ca)); // R10
  AST_OV_OFF: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !ovf_en) |=> ($stable(ov) && $stable(ov32) && $stable(so))); // R11
endmodule

// File: tb/test_fxu_flag_unit.sv
module test_fxu_flag_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        upd_valid, b_used, inv_a, imm_valid, is_add;
  logic        carry_en, ovf_en, rec_en, div_ovf_valid, div_ovf_bit;
  logic [63:0] op_a, op_b, imm_data, result;
  logic [2:0]  cr_sel;
  logic [1:0]  carry_skip;
  logic        ca, ca32, ov, ov32, so;
  logic [31:0] cr_bits;

  int checks = 0;
  int errors = 0;
  logic e_ca, e_ca32, e_ov, e_ov32, e_so;
  logic [31:0] e_cr;

  always #10 clk = ~clk;

  fxu_flag_unit i_fxu_flag_unit (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .op_a(op_a), .op_b(op_b),
    .b_used(b_used), .inv_a(inv_a), .imm_valid(imm_valid), .imm_data(imm_data),
    .result(result), .is_add(is_add), .carry_en(carry_en), .ovf_en(ovf_en),
    .rec_en(rec_en), .cr_sel(cr_sel), .div_ovf_valid(div_ovf_valid),
    .div_ovf_bit(div_ovf_bit), .carry_skip(carry_skip), .ca(ca), .ca32(ca32),
    .ov(ov), .ov32(ov32), .so(so), .cr_bits(cr_bits)
  );

  task automatic idle_inputs();
    upd_valid = 0; b_used = 1; inv_a = 0; imm_valid = 0; is_add = 0;
    carry_en = 0; ovf_en = 0; rec_en = 0; div_ovf_valid = 0; div_ovf_bit = 0;
    op_a = '0; op_b = '0; imm_data = '0; result = '0; cr_sel = '0; carry_skip = '0;
  endtask

  task automatic pulse(input logic vld);
    upd_valid = vld;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_all(input string req);
    checks++;
    if ({ca, ca32, ov, ov32, so} !== {e_ca, e_ca32, e_ov, e_ov32, e_so} || cr_bits !== e_cr) begin
      errors++;
      $display("FAIL %s flags=%b cr=%h expected flags=%b cr=%h", req,
               {ca, ca32, ov, ov32, so}, cr_bits,
               {e_ca, e_ca32, e_ov, e_ov32, e_so}, e_cr);
    end
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    e_ca = 0; e_ca32 = 0; e_ov = 0; e_ov32 = 0; e_so = 0; e_cr = '0;
    check_all("R1 reset");
  endtask

  task automatic t_cr_plain();
    rec_en = 1; cr_sel = 3'd2; result = 64'd5;
    pulse(1);
    e_cr[11:8] = 4'b0100;
    check_all("R9 positive field 2");
  endtask

  task automatic t_add_carry();
    carry_en = 1; is_add = 1; op_a = '1; op_b = 64'd1; result = 64'd0;
    pulse(1);
    e_ca = 1; e_ca32 = 1;
    check_all("R4 R5 add wrap");
    carry_en = 1; is_add = 1; op_a = 64'h0000_0000_FFFF_FFFF; op_b = 64'd1;
    result = 64'h0000_0001_0000_0000;
    pulse(1);
    e_ca = 0; e_ca32 = 1;
    check_all("R5 add bit32 xor");
  endtask

  task automatic t_logic_carry32();
    carry_en = 1; op_a = 64'h0000_0001_0000_0005; op_b = '0;
    result = 64'h0000_0002_0000_0003;
    pulse(1);
    e_ca = 0; e_ca32 = 1;
    check_all("R5 non-add low compare");
    carry_en = 1; b_used = 0; op_a = 64'd3; op_b = '1; result = 64'd7;
    pulse(1);
    e_ca = 0; e_ca32 = 0;
    check_all("R4 single operand");
  endtask

  task automatic t_invert_imm();
    carry_en = 1; is_add = 1; inv_a = 1; op_a = '0; op_b = 64'd1; result = '0;
    pulse(1);
    e_ca = 1; e_ca32 = 1;
    check_all("R3 invert a");
    carry_en = 1; imm_valid = 1; imm_data = 64'h10; op_a = 64'h1; op_b = 64'hFF;
    result = 64'h10;
    pulse(1);
    e_ca = 0; e_ca32 = 0;
    check_all("R3 imm replaces b carry");
    ovf_en = 1; imm_valid = 1; imm_data = 64'd1; op_a = 64'h7FFF_FFFF_FFFF_FFFF;
    op_b = 64'h8000_0000_0000_0000; result = 64'h8000_0000_0000_0000;
    pulse(1);
    e_ov = 1; e_ov32 = 0; e_so = 1;
    check_all("R3 imm replaces b overflow");
  endtask

  task automatic t_skip();
    carry_en = 1; op_a = '1; op_b = 64'd1; result = '0; carry_skip = 2'b01;
    pulse(1);
    e_ca32 = 1;
    check_all("R10 skip ca");
    carry_en = 1; op_a = 64'd5; op_b = 64'd3; result = 64'd8; carry_skip = 2'b10;
    pulse(1);
    e_ca = 0;
    check_all("R10 skip ca32");
    op_a = '1; op_b = 64'd1; result = '0;
    pulse(1);
    check_all("R11 carry disabled");
  endtask

  task automatic t_no_valid();
    carry_en = 1; ovf_en = 1; rec_en = 1; cr_sel = 3'd5; div_ovf_valid = 1;
    div_ovf_bit = 0; op_a = '1; op_b = 64'd1; result = '0;
    pulse(0);
    check_all("R2 strobe low");
  endtask

  task automatic t_overflow();
    rst = 1; @(negedge clk); rst = 0;
    e_ca = 0; e_ca32 = 0; e_ov = 0; e_ov32 = 0; e_so = 0; e_cr = '0;
    ovf_en = 1; rec_en = 1; cr_sel = 3'd1; op_a = 64'h7FFF_FFFF_FFFF_FFFF;
    op_b = 64'd1; result = 64'h8000_0000_0000_0000;
    pulse(1);
    e_ov = 1; e_ov32 = 0; e_so = 1; e_cr[7:4] = 4'b1001;
    check_all("R6 R9 64-bit overflow new so");
    ovf_en = 1; op_a = 64'h7FFF_FFFF; op_b = 64'd1; result = 64'h8000_0000;
    pulse(1);
    e_ov = 0; e_ov32 = 1;
    check_all("R6 R8 low word overflow sticky so");
    ovf_en = 1; b_used = 0; op_a = 64'd1; result = 64'd2;
    pulse(1);
    check_all("R6 single operand keeps ov");
    ovf_en = 0; op_a = 64'd5; op_b = 64'd5; result = 64'd10;
    pulse(1);
    check_all("R11 overflow disabled");
    ovf_en = 1; div_ovf_valid = 1; div_ovf_bit = 0; op_a = 64'h7FFF_FFFF_FFFF_FFFF;
    op_b = 64'd1; result = 64'h8000_0000_0000_0000;
    pulse(1);
    e_ov = 0; e_ov32 = 0;
    check_all("R7 R8 divide clear keeps so");
    rec_en = 1; cr_sel = 3'd7; result = '0;
    pulse(1);
    e_cr[31:28] = 4'b0011;
    check_all("R9 zero field 7");
  endtask

  task automatic t_div_first();
    rst = 1; @(negedge clk); rst = 0;
    e_ca = 0; e_ca32 = 0; e_ov = 0; e_ov32 = 0; e_so = 0; e_cr = '0;
    ovf_en = 1; div_ovf_valid = 1; div_ovf_bit = 1; op_a = 64'd4; op_b = 64'd2;
    result = 64'd2; rec_en = 1; cr_sel = 3'd0;
    pulse(1);
    e_ov = 1; e_ov32 = 1; e_so = 1; e_cr[3:0] = 4'b0101;
    check_all("R7 divide overflow both");
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk);
    t_reset();
    t_cr_plain();
    t_add_carry();
    t_logic_carry32();
    t_invert_imm();
    t_skip();
    t_no_valid();
    t_overflow();
    t_div_first();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule